// File: doc/BRIEF.md
# Vector Length Configuration Unit

This unit carries out the three vector configuration operations of a vector-capable core. Each operation asks for a new element type and an application vector length (AVL). The unit holds the architectural vector length (vl) and vector type (vtype) state. It checks the requested type word for legality and derives the largest vector length that the type allows (VLMAX). It then writes the clamped length into vl and returns the same value for the destination register.

The decoder supplies a request that carries the operation form, the rs1 and rs2 operand values, the immediate fields, and flags that mark rs1 and rd as register zero. One cycle later the unit drives the result, the updated vl and vtype, and a pulse that clears the vector start index.

The next request always sees the updated state, so back-to-back configuration operations are serialised without any stall.

Top module: `vcfg_unit`

## Requirements
- R1: While reset is high and after it, until the first request, vl reads 0 and vtype reads a word whose only set bit is the top bit (XLEN-1, the illegal-type flag). rsp_valid and vstart_clr are 0.
- R2: req_form selects the operands. For form 0 the AVL is rs1 and the type is imm[10:0], zero-extended. For form 1 the AVL is rs1 and the type is the full rs2 value. For form 2 the AVL is the 5-bit uimm and the type is imm[9:0], zero-extended, so imm[10] is ignored. Form 3 behaves as form 1.
- R3: In the type word, bits 2:0 (lmul code) give LMUL = 1, 2, 4 or 8 for codes 0 to 3 and 1/8, 1/4 or 1/2 for codes 5 to 7. Bits 5:3 (sew code) give SEW = 8 << code. Bits 7:6 are free policy bits. For a legal type, VLMAX = (VLEN / SEW) * LMUL, with VLEN = 8 * VLENB.
- R4: A type is illegal when the lmul code is 4, or SEW > min(LMUL,1) * ELEN, or any bit from 8 to XLEN-1 is set. An illegal type stores vtype = 1 << (XLEN-1) and uses VLMAX = 0.
- R5: When the requested type word equals the current vtype, vtype is kept unchanged and the VLMAX of the current vtype is used. That VLMAX is 0 if the current vtype has its illegal-type flag set.
- R6: The new vl is min(AVL, VLMAX). It is written to vl and driven on rsp_rd_data.
- R7: For forms 0, 1 and 3, rs1 = x0 with rd ≠ x0 makes the AVL all ones, so vl becomes VLMAX. rs1 = x0 with rd = x0 makes the AVL the current vl, which is then clamped to the new VLMAX. Form 2 ignores both flags.
- R8: A request accepted at a rising edge shows its result in the cycle after that edge, with rsp_valid high for one cycle. A request in the very next cycle uses the updated vl and vtype.
- R9: vstart_clr pulses high for exactly the cycles in which rsp_valid is high.
- R10: A cycle without req_valid leaves vl and vtype unchanged and keeps rsp_valid low, whatever the other inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Configuration request present |
| req_form | input | 2 | Operation form (0: reg AVL/imm type, 1: reg AVL/reg type, 2: imm AVL/imm type) |
| req_rs1_val | input | XLEN | rs1 operand value |
| req_rs2_val | input | XLEN | rs2 operand value |
| req_imm | input | 11 | Type immediate |
| req_uimm | input | 5 | AVL immediate |
| req_rs1_zero | input | 1 | rs1 is register zero |
| req_rd_zero | input | 1 | rd is register zero |
| rsp_valid | output | 1 | Result valid |
| rsp_rd_data | output | XLEN | Value for the destination register |
| vstart_clr | output | 1 | Clear the vector start index |
| vl_o | output | VL_W | Current vector length |
| vtype_o | output | XLEN | Current vector type word |

## Verification
A full sweep of all 64 sew/lmul code pairs through the register-type form, with a varying AVL, separates legal from illegal combinations and exercises both the integer and the fractional VLMAX scaling. Targeted words place a single reserved bit at bit 8, at bit 62 and at the flag bit, which shows that the reserved-bit check covers its whole range. Some requests repeat the current type, including the illegal-type word, and these tell the reuse path apart from a fresh check. The register-zero flag combinations, used in both register and immediate forms, distinguish the "request maximum", "keep vl" and "flags ignored" behaviours, and idle cycles driven with random operands confirm that the state holds.

// File: rtl/vcfg_pkg.sv
package vcfg_pkg;
  typedef enum logic [1:0] {
    CFG_REG_IMM = 2'd0,
    CFG_REG_REG = 2'd1,
    CFG_IMM_IMM = 2'd2
  } cfg_form_e;

  localparam int LMUL_LSB = 0;
  localparam int SEW_LSB  = 3;
  localparam int RSV_LSB  = 8;
  localparam logic [2:0] LMUL_RSV_CODE = 3'd4;
endpackage

// File: rtl/vcfg_type_check.sv
module vcfg_type_check
  import vcfg_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int VLEN = 128,
  parameter int ELEN = 64,
  parameter int VL_W = 8
) (
  input  logic [XLEN-1:0] vtype_i,
  output logic            legal_o,
  output logic [VL_W-1:0] vlmax_o
);
  logic [2:0]  lmul_code;
  logic [2:0]  sew_code;
  logic        frac;
  logic [2:0]  frac_sh;
  logic [31:0] sew_bits;
  logic [31:0] elen_lim;
  logic [31:0] base;
  logic [31:0] scaled;
  logic        rsv_clear;
  logic        unused_policy;

  assign lmul_code     = vtype_i[LMUL_LSB +: 3];
  assign sew_code      = vtype_i[SEW_LSB +: 3];
  assign unused_policy = ^vtype_i[RSV_LSB-1:SEW_LSB+3];
  assign frac          = lmul_code[2];
  assign frac_sh       = 3'd0 - lmul_code;

  always_comb begin
    sew_bits  = 32'd8 << sew_code;
    elen_lim  = frac ? (32'(ELEN) >> frac_sh) : 32'(ELEN);
    rsv_clear = ~|vtype_i[XLEN-1:RSV_LSB];
    legal_o   = (lmul_code != LMUL_RSV_CODE) && (sew_bits <= elen_lim) && rsv_clear;
    base      = 32'(VLEN) >> (32'd3 + 32'(sew_code));
    scaled    = frac ? (base >> frac_sh) : (base << lmul_code[1:0]);
    vlmax_o   = legal_o ? VL_W'(scaled) : '0;
  end
endmodule

// File: rtl/vcfg_avl_sel.sv
module vcfg_avl_sel
  import vcfg_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int VL_W = 8
) (
  input  logic [1:0]      form_i,
  input  logic [XLEN-1:0] rs1_val_i,
  input  logic [4:0]      uimm_i,
  input  logic            rs1_zero_i,
  input  logic            rd_zero_i,
  input  logic [VL_W-1:0] cur_vl_i,
  input  logic [VL_W-1:0] vlmax_i,
  output logic [VL_W-1:0] new_vl_o
);
  logic [XLEN-1:0] avl;

  always_comb begin
    if (cfg_form_e'(form_i) == CFG_IMM_IMM)
      avl = XLEN'(uimm_i);
    else if (rs1_zero_i && !rd_zero_i)
      avl = '1;
    else if (rs1_zero_i)
      avl = XLEN'(cur_vl_i);
    else
      avl = rs1_val_i;
    new_vl_o = (avl > XLEN'(vlmax_i)) ? vlmax_i : VL_W'(avl);
  end
endmodule

// File: rtl/vcfg_unit.sv
module vcfg_unit
  import vcfg_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int VLENB = 16,
  parameter int ELEN  = 64,
  localparam int VLEN = VLENB * 8,
  localparam int VL_W = $clog2(VLEN + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  input  logic [1:0]      req_form,
  input  logic [XLEN-1:0] req_rs1_val,
  input  logic [XLEN-1:0] req_rs2_val,
  input  logic [10:0]     req_imm,
  input  logic [4:0]      req_uimm,
  input  logic            req_rs1_zero,
  input  logic            req_rd_zero,
  output logic            rsp_valid,
  output logic [XLEN-1:0] rsp_rd_data,
  output logic            vstart_clr,
  output logic [VL_W-1:0] vl_o,
  output logic [XLEN-1:0] vtype_o
);
  localparam logic [XLEN-1:0] VILL_WORD = {1'b1, {(XLEN-1){1'b0}}};

  logic [XLEN-1:0] req_type;
  logic            req_legal;
  logic [VL_W-1:0] req_vlmax;
  logic            cur_legal;
  logic [VL_W-1:0] cur_vlmax;
  logic            same_type;
  logic [XLEN-1:0] next_vtype;
  logic [VL_W-1:0] next_vlmax;
  logic [VL_W-1:0] next_vl;
  logic            unused_cur_legal;

  always_comb begin
    case (cfg_form_e'(req_form))
      CFG_REG_IMM: req_type = XLEN'(req_imm);
      CFG_IMM_IMM: req_type = XLEN'(req_imm[9:0]);
      default:     req_type = req_rs2_val;
    endcase
  end

  vcfg_type_check #(.XLEN(XLEN), .VLEN(VLEN), .ELEN(ELEN), .VL_W(VL_W)) u_req_chk (
    .vtype_i (req_type),
    .legal_o (req_legal),
    .vlmax_o (req_vlmax)
  );

  vcfg_type_check #(.XLEN(XLEN), .VLEN(VLEN), .ELEN(ELEN), .VL_W(VL_W)) u_cur_chk (
    .vtype_i (vtype_o),
    .legal_o (cur_legal),
    .vlmax_o (cur_vlmax)
  );
  assign unused_cur_legal = cur_legal;

  assign same_type  = (req_type == vtype_o);
  assign next_vtype = same_type ? vtype_o : (req_legal ? req_type : VILL_WORD);
  assign next_vlmax = same_type ? cur_vlmax : req_vlmax;

  vcfg_avl_sel #(.XLEN(XLEN), .VL_W(VL_W)) u_avl (
    .form_i     (req_form),
    .rs1_val_i  (req_rs1_val),
    .uimm_i     (req_uimm),
    .rs1_zero_i (req_rs1_zero),
    .rd_zero_i  (req_rd_zero),
    .cur_vl_i   (vl_o),
    .vlmax_i    (next_vlmax),
    .new_vl_o   (next_vl)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid   <= 1'b0;
      vstart_clr  <= 1'b0;
      rsp_rd_data <= '0;
      vl_o        <= '0;
      vtype_o     <= VILL_WORD;
    end else begin
      rsp_valid  <= req_valid;
      vstart_clr <= req_valid;
      if (req_valid) begin
        rsp_rd_data <= XLEN'(next_vl);
        vl_o        <= next_vl;
        vtype_o     <= next_vtype;
      end
    end
  end

  // R4: illegal flag means an otherwise empty word and zero length
  a_r4_vill_word: assert property (@(posedge clk) disable iff (rst)
    vtype_o[XLEN-1] |-> (vtype_o[XLEN-2:0] == '0) && (vl_o == '0));
  // R4: a stored legal type never carries the reserved lmul code
  a_r4_no_rsv_lmul: assert property (@(posedge clk) disable iff (rst)
    !vtype_o[XLEN-1] |-> (vtype_o[2:0] != LMUL_RSV_CODE));
  // R5: matching request keeps vtype
  a_r5_same_keeps: assert property (@(posedge clk) disable iff (rst)
    (req_valid && same_type) |=> $stable(vtype_o));
  // R6: destination value equals the new vl
  a_r6_rd_is_vl: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_rd_data == XLEN'(vl_o)));
  // R7: rs1 zero with rd nonzero requests the maximum
  a_r7_max_req: assert property (@(posedge clk) disable iff (rst)
    (req_valid && (req_form != 2'd2) && req_rs1_zero && !req_rd_zero)
      |=> (vl_o == $past(next_vlmax)));
  // R8, R9: one-cycle response and vstart clear pulse
  a_r8_resp: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> (rsp_valid && vstart_clr));
  // R10: idle cycle holds state
  a_r10_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!rsp_valid && !vstart_clr && $stable(vl_o) && $stable(vtype_o)));
endmodule

// File: tb/tb_vcfg_unit.sv
module tb_vcfg_unit;
  localparam int XLEN = 64;
  localparam int VLEN = 128;
  localparam int ELEN = 64;
  localparam int VL_W = 8;
  localparam logic [63:0] VILL = 64'h8000_0000_0000_0000;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            req_valid = 1'b0;
  logic [1:0]      req_form = '0;
  logic [63:0]     req_rs1_val = '0;
  logic [63:0]     req_rs2_val = '0;
  logic [10:0]     req_imm = '0;
  logic [4:0]      req_uimm = '0;
  logic            req_rs1_zero = 1'b0;
  logic            req_rd_zero = 1'b0;
  logic            rsp_valid;
  logic [63:0]     rsp_rd_data;
  logic            vstart_clr;
  logic [VL_W-1:0] vl_o;
  logic [63:0]     vtype_o;

  int vectors = 0;
  int fails = 0;
  bit done = 0;
  logic [63:0] m_vl = '0;
  logic [63:0] m_vtype = VILL;

  always #5 clk = ~clk;

  vcfg_unit #(.XLEN(XLEN), .VLENB(VLEN/8), .ELEN(ELEN)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_form(req_form),
    .req_rs1_val(req_rs1_val), .req_rs2_val(req_rs2_val), .req_imm(req_imm),
    .req_uimm(req_uimm), .req_rs1_zero(req_rs1_zero), .req_rd_zero(req_rd_zero),
    .rsp_valid(rsp_valid), .rsp_rd_data(rsp_rd_data), .vstart_clr(vstart_clr),
    .vl_o(vl_o), .vtype_o(vtype_o)
  );

  function automatic logic [63:0] mdl_vlmax(input logic [63:0] t, output bit ok);
    int sew, num, den, code;
    code = int'(t[2:0]);
    sew  = 8 << int'(t[5:3]);
    num = 1; den = 1;
    if (code < 4) num = 1 << code;
    else if (code > 4) den = 1 << (8 - code);
    ok = (code != 4) && (t[63:8] == '0) && (sew * den <= ELEN);
    return ok ? 64'((VLEN * num) / (sew * den)) : 64'd0;
  endfunction

  task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag, bit v, logic [1:0] f, logic [63:0] rs1, logic [63:0] rs2,
                      logic [10:0] imm, logic [4:0] u, bit z1, bit zd);
    logic [63:0] rt, nt, vm, avl, nvl;
    bit ok;
    req_valid = v; req_form = f; req_rs1_val = rs1; req_rs2_val = rs2;
    req_imm = imm; req_uimm = u; req_rs1_zero = z1; req_rd_zero = zd;
    rt = (f == 2'd2) ? 64'(imm[9:0]) : (f == 2'd0) ? 64'(imm) : rs2;
    if (rt == m_vtype) begin
      nt = m_vtype;
      vm = mdl_vlmax(m_vtype, ok);
    end else begin
      vm = mdl_vlmax(rt, ok);
      nt = ok ? rt : VILL;
    end
    if (f == 2'd2) avl = 64'(u);
    else if (z1 && !zd) avl = '1;
    else if (z1) avl = m_vl;
    else avl = rs1;
    nvl = (avl > vm) ? vm : avl;
    @(posedge clk);
    #2;
    vectors++;
    if (v) begin
      m_vl = nvl;
      m_vtype = nt;
      check(tag, "rd", rsp_rd_data, nvl);
    end
    check(tag, "rsp_valid", 64'(rsp_valid), 64'(v));
    check(tag, "vstart_clr", 64'(vstart_clr), 64'(v));
    check(tag, "vl", 64'(vl_o), m_vl);
    check(tag, "vtype", vtype_o, m_vtype);
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    vectors++;
    check("R1", "vl", 64'(vl_o), 64'd0);
    check("R1", "vtype", vtype_o, VILL);
    check("R1", "rsp_valid", 64'(rsp_valid), 64'd0);
    check("R1", "vstart_clr", 64'(vstart_clr), 64'd0);
    rst = 1'b0;
    @(negedge clk);
    vectors++;
    check("R1", "vl after reset", 64'(vl_o), 64'd0);
    check("R1", "vtype after reset", vtype_o, VILL);

    // R2 forms, R3 VLMAX scaling, R6 clamp
    step("R2", 1, 2'd0, 64'd100, 64'hFF, 11'h009, 5'd0, 0, 0);
    step("R6", 1, 2'd0, 64'd5, 64'h0, 11'h009, 5'd0, 0, 0);
    step("R2", 1, 2'd1, 64'd7, 64'h58, 11'h7FF, 5'd0, 0, 0);
    step("R2", 1, 2'd2, 64'd0, 64'h0, 11'h003, 5'd31, 0, 0);
    step("R2", 1, 2'd2, 64'd0, 64'h0, 11'h405, 5'd9, 1, 1);
    step("R2", 1, 2'd3, 64'd40, 64'h07, 11'h000, 5'd0, 0, 0);
    step("R3", 1, 2'd1, 64'd200, 64'h05, 11'h0, 5'd0, 0, 0);
    // R4 illegal cases
    step("R4", 1, 2'd1, 64'd10, 64'h04, 11'h0, 5'd0, 0, 0);
    step("R4", 1, 2'd1, 64'd10, 64'h16, 11'h0, 5'd0, 0, 0);
    step("R4", 1, 2'd1, 64'd10, 64'h20, 11'h0, 5'd0, 0, 0);
    step("R4", 1, 2'd1, 64'd10, 64'h100, 11'h0, 5'd0, 0, 0);
    step("R4", 1, 2'd1, 64'd10, 64'h4000_0000_0000_0000, 11'h0, 5'd0, 0, 0);
    step("R4", 1, 2'd0, 64'd10, 64'h0, 11'h101, 5'd0, 0, 0);
    step("R4", 1, 2'd1, 64'd3, 64'h8000_0000_0000_0001, 11'h0, 5'd0, 0, 0);
    // R5 same type
    step("R5", 1, 2'd1, 64'd9, VILL, 11'h0, 5'd0, 0, 0);
    step("R5", 1, 2'd1, 64'd50, 64'hC0, 11'h0, 5'd0, 0, 0);
    step("R5", 1, 2'd1, 64'd70, 64'hC0, 11'h0, 5'd0, 0, 0);
    // R7 register-zero flags
    step("R7", 1, 2'd0, 64'd3, 64'h0, 11'h001, 5'd0, 1, 0);
    step("R7", 1, 2'd0, 64'd3, 64'h0, 11'h008, 5'd0, 1, 1);
    step("R7", 1, 2'd1, 64'd3, 64'h03, 11'h0, 5'd0, 1, 1);
    step("R7", 1, 2'd1, 64'd3, 64'h03, 11'h0, 5'd0, 0, 1);
    // R10 idle cycles with noise, R9 pulse checked in each step
    for (int i = 0; i < 6; i++)
      step("R10", 0, 2'(i), {$urandom, $urandom}, {$urandom, $urandom},
           11'($urandom), 5'($urandom), 1'(i), 1'(i >> 1));
    // R3, R4, R8 back-to-back sweep
    for (int s = 0; s < 8; s++)
      for (int m = 0; m < 8; m++)
        step("R8", 1, 2'd1, 64'(s * 37 + m), 64'((s << 3) | m), 11'h0, 5'd0, 0, 0);
    step("R9", 0, 2'd0, 64'd0, 64'd0, 11'h0, 5'd0, 0, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule